// File: doc/BRIEF.md
# Maskable AND/OR Coincidence Unit

This block turns a wide vector of conditioned trigger bits into one decision per clock. A per-input enable mask picks the bits that take part, and a mode input picks whether the picked bits are ORed (any one fires) or ANDed (all must fire). The registered decision is brought out directly. A second copy passes through a programmable delay line and a gate stretcher, and that copy feeds later trigger stages. Each rising edge of the undelayed decision advances a 24-bit event counter.

Two variants come from one module. The first-level form has 64 inputs and uses the gate width that the gate input gives. The second-level form is built with its input width widened to take the 64 channels plus the delayed and gated first-level results. In that form the parameter `ONE_TICK` is set, so every output pulse lasts exactly one clock whatever the gate setting is. Register decoding and the number of units built are left to the parent.

Top module: `coinc_unit`

## Requirements
- R1: An input bit whose mask bit is 0 never affects `raw_o`.
- R2: With `mode_i` = 0 (OR), `raw_o` is 1 one clock after any input with its mask bit set is high, and 0 otherwise.
- R3: With `mode_i` = 1 (AND), `raw_o` is 1 one clock after all masked-in inputs are high. An all-zero mask gives `raw_o` = 0 in either mode.
- R4: A rising edge of `raw_o` after clock edge k makes `timed_o` rise after edge k+`delay_i`+1, for `delay_i` from 0 to 2^DLY_W-1.
- R5: In the first-level form `timed_o` stays high for `gate_i` clocks per rising edge, and a `gate_i` of 0 is taken as 1.
- R6: With `ONE_TICK` = 1 (second-level form) every `timed_o` pulse lasts exactly one clock, whatever `gate_i` is.
- R7: `count_o` rises by exactly one per rising edge of `raw_o`, one clock after the edge. A level held high counts once. The count wraps modulo 2^CNT_W.
- R8: While `rst_ni` is low, `raw_o`, `timed_o` and `count_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Trigger clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | N_IN | Conditioned channel bits (plus first-level results in the second-level form) |
| mask_i | input | N_IN | Per-input enable, 1 = takes part |
| mode_i | input | 1 | Combine mode: 0 = OR, 1 = AND |
| delay_i | input | DLY_W | Output delay in clocks |
| gate_i | input | GATE_W | Output gate width in clocks (0 acts as 1) |
| raw_o | output | 1 | Registered combine result before timing |
| timed_o | output | 1 | Delayed and gated result |
| count_o | output | CNT_W | Count of rising edges of `raw_o` |

## Verification
A bad mask or mode decode shows on `raw_o` one clock after the input pattern is applied. The test table holds unmasked set bits and near-miss AND patterns, so that kind of fault cannot hide. A delay-line or gate-counter fault moves or resizes the `timed_o` window. Each timing case is compared cycle by cycle, so an error of one clock is caught on the first edge where it occurs. A counter that misses an edge, or counts a held level again, is off by the next count sample, which is taken a few clocks after the stimulus ends.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef enum logic {
    MODE_OR  = 1'b0,
    MODE_AND = 1'b1
  } coinc_mode_e;
endpackage

// File: rtl/coinc_combine.sv
module coinc_combine
  import coinc_pkg::*;
#(
  parameter int N_IN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] in_i,
  input  logic [N_IN-1:0] mask_i,
  input  logic            mode_i,
  output logic            raw_o
);
  coinc_mode_e mode;
  logic        any_hit, all_hit, any_en, comb;

  assign mode    = coinc_mode_e'(mode_i);
  assign any_en  = |mask_i;
  assign any_hit = |(in_i & mask_i);
  // an empty mask must not turn AND into a constant 1
  assign all_hit = any_en & (&(in_i | ~mask_i));
  assign comb    = (mode == MODE_AND) ? all_hit : any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_o <= 1'b0;
    else         raw_o <= comb;
  end

  a_r3_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !raw_o);
  a_r2_or_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && ((in_i & mask_i) != '0)) |=> raw_o);
  a_r3_and_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && ((~in_i & mask_i) != '0)) |=> !raw_o);
endmodule

// File: rtl/coinc_delay_gate.sv
module coinc_delay_gate #(
  parameter int DLY_W    = 4,
  parameter int GATE_W   = 8,
  parameter bit ONE_TICK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [GATE_W-1:0] gate_i,
  output logic              timed_o
);
  localparam int MAX_DLY = 1 << DLY_W;

  logic [MAX_DLY-2:0] sr_q;
  logic [MAX_DLY-1:0] taps;
  logic               dly, dly_q, rise;
  logic [GATE_W-1:0]  load, gate_q;

  // taps[j] is raw_i delayed by j clocks
  assign taps = {sr_q, raw_i};
  assign dly  = taps[delay_i];
  assign rise = dly & ~dly_q;

  generate
    if (ONE_TICK) begin : g_one_tick
      assign load = GATE_W'(1);
    end else begin : g_prog_gate
      assign load = (gate_i == '0) ? GATE_W'(1) : gate_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dly_q  <= 1'b0;
      gate_q <= '0;
    end else begin
      sr_q  <= taps[MAX_DLY-2:0];
      dly_q <= dly;
      if (rise)              gate_q <= load;
      else if (gate_q != '0) gate_q <= gate_q - GATE_W'(1);
    end
  end

  assign timed_o = (gate_q != '0);

  a_r5_gate_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> timed_o);
  a_r6_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ONE_TICK && timed_o) |=> !timed_o);
  a_r4_zero_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delay_i == '0 && $rose(raw_i)) |=> timed_o);
endmodule

// File: rtl/coinc_counter.sv
module coinc_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  output logic [CNT_W-1:0] count_o
);
  logic raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q   <= 1'b0;
      count_o <= '0;
    end else begin
      raw_q <= raw_i;
      if (raw_i && !raw_q) count_o <= count_o + CNT_W'(1);
    end
  end

  a_r7_step_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_i) |=> (count_o == $past(count_o) + CNT_W'(1)));
  a_r7_hold_on_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(raw_i) |=> $stable(count_o));
endmodule

// File: rtl/coinc_unit.sv
module coinc_unit #(
  parameter int N_IN     = 64,
  parameter int DLY_W    = 4,
  parameter int GATE_W   = 8,
  parameter int CNT_W    = 24,
  parameter bit ONE_TICK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_IN-1:0]   mask_i,
  input  logic              mode_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [GATE_W-1:0] gate_i,
  output logic              raw_o,
  output logic              timed_o,
  output logic [CNT_W-1:0]  count_o
);
  logic raw;

  coinc_combine #(.N_IN(N_IN)) u_combine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (in_i),
    .mask_i (mask_i),
    .mode_i (mode_i),
    .raw_o  (raw)
  );

  coinc_delay_gate #(.DLY_W(DLY_W), .GATE_W(GATE_W), .ONE_TICK(ONE_TICK)) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw),
    .delay_i (delay_i),
    .gate_i  (gate_i),
    .timed_o (timed_o)
  );

  coinc_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw),
    .count_o (count_o)
  );

  assign raw_o = raw;

  a_r8_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!raw_o && !timed_o && count_o == '0));
endmodule

// File: tb/coinc_unit_test.sv
module coinc_unit_test;
  localparam int N1 = 64;
  localparam int N2 = 74;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [N1-1:0] in1 = '0, mask1 = '0;
  logic          mode1 = 1'b0;
  logic [3:0]    dly1 = '0;
  logic [7:0]    gate1 = '0;
  logic          raw1, timed1;
  logic [23:0]   cnt1;

  logic [N2-1:0] in2 = '0, mask2 = '0;
  logic [3:0]    dly2 = '0;
  logic [7:0]    gate2 = '0;
  logic          raw2, timed2;
  logic [23:0]   cnt2;

  coinc_unit #(.N_IN(N1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(in1), .mask_i(mask1), .mode_i(mode1),
    .delay_i(dly1), .gate_i(gate1), .raw_o(raw1), .timed_o(timed1), .count_o(cnt1));

  coinc_unit #(.N_IN(N2), .ONE_TICK(1'b1)) uut_l2 (
    .clk_i(clk), .rst_ni(rst_ni), .in_i(in2), .mask_i(mask2), .mode_i(1'b0),
    .delay_i(dly2), .gate_i(gate2), .raw_o(raw2), .timed_o(timed2), .count_o(cnt2));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // {mode, mask, in, expected raw}
  typedef struct packed {
    logic          mode;
    logic [N1-1:0] mask;
    logic [N1-1:0] in;
    logic          exp;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 64'hF, 64'h1, 1'b1},                                 // R2
    '{1'b0, 64'hF, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0},               // R1
    '{1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},               // R3 empty
    '{1'b1, 64'hF, 64'hF, 1'b1},                                 // R3
    '{1'b1, 64'hF, 64'h7, 1'b0},                                 // R3
    '{1'b1, 64'hF, 64'hFFFF_FFFF_FFFF_FFF7, 1'b0},               // R1/R3
    '{1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},               // R3 empty
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    '{1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1},
    '{1'b0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0}  // R1
  };

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    in1 = '0; mask1 = '0; mode1 = 1'b0; in2 = '0; mask2 = '0;
    repeat (2) @(negedge clk);
    chk("R8 raw", raw1, 0);
    chk("R8 timed", timed1, 0);
    chk("R8 count", cnt1, 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_timing(input int d, input int g);
    int gw;
    gw = (g == 0) ? 1 : g;
    mode1 = 1'b0; mask1 = 64'h1; in1 = '0;
    dly1 = 4'(d); gate1 = 8'(g);
    repeat (20) @(negedge clk);
    in1 = 64'h1;
    for (int n = 1; n <= d + gw + 3; n++) begin
      @(negedge clk);
      chk($sformatf("R4/R5 d=%0d g=%0d n=%0d", d, g, n), timed1,
          (n >= d + 2 && n <= d + 1 + gw) ? 1 : 0);
    end
    in1 = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int rises;
    logic prev;
    do_reset();
    // combine table, with bench-side count of raw rises for R7
    rises = 0; prev = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode1 = VEC[i].mode; mask1 = VEC[i].mask; in1 = VEC[i].in;
      @(negedge clk);
      chk($sformatf("R1/R2/R3 vec %0d", i), raw1, VEC[i].exp);
      if (VEC[i].exp && !prev) rises++;
      prev = VEC[i].exp;
    end
    in1 = '0;
    repeat (2) @(negedge clk);
    chk("R7 table count", cnt1, rises);

    // timing: zero delay, zero gate, mid values, maximum delay
    run_timing(0, 0);
    run_timing(3, 4);
    run_timing(15, 2);
    run_timing(1, 1);

    // counter: 5 pulses then a long level counts 6
    do_reset();
    mode1 = 1'b0; mask1 = 64'h1;
    for (int p = 0; p < 5; p++) begin
      in1 = 64'h1; repeat (2) @(negedge clk);
      in1 = '0;    repeat (2) @(negedge clk);
    end
    in1 = 64'h1; repeat (10) @(negedge clk);
    in1 = '0;    repeat (2) @(negedge clk);
    chk("R7 pulse count", cnt1, 6);

    // second-level form: input above 64, gate forced to one tick
    mask2 = '0; mask2[70] = 1'b1; dly2 = 4'd2; gate2 = 8'd5; in2 = '0;
    repeat (4) @(negedge clk);
    in2[70] = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      if (n == 1) chk("R2 l2 raw", raw2, 1);
      chk($sformatf("R6 l2 n=%0d", n), timed2, (n == 4) ? 1 : 0);
    end
    in2 = '0; in2[69] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 l2 masked-out", raw2, 0);
    chk("R7 l2 count", cnt2, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule